// File: doc/BRIEF.md
# Chainable Serial Command Register Port

This block accepts 16-bit command words over three slow serial pins (a data line, a shift clock and a load strobe) and turns each word into a write to a small register file. The register file holds eight 8-bit digit registers and the control settings a multiplexed seven-segment display engine needs: per-digit decode enables, a 4-bit brightness level, a 3-bit scan limit, a shutdown flag, a display-test flag and a configuration register with a soft-reset bit and an external-clock select bit. All register contents leave the block as parallel outputs for the display logic that sits beside it.

The serial pins are sampled by a fast system clock through two-flop synchronizers, and edges are found on the synchronized copies. A serial output repeats the most significant bit of the shift register, changing on falling shift-clock edges, so several identical blocks can be chained data-out to data-in and share one clock and one load strobe. A command reaches the k-th block in the chain when it is followed by k-1 frames that target the no-operation address before the strobe.

Top module: `seg_cmd_port`

## Requirements
- R1: After the synchronous reset every digit register is 0, decode mode is 0x00, intensity is 0, scan limit is 0, shutdown is active, display test is off, soft reset and external clock select are 0, and the serial output is 0.
- R2: A frame is shifted in most significant bit first, one bit per rising shift-clock edge; bits 11:8 of the last 16 bits form the address, bits 7:0 the data, and bits 15:12 have no effect.
- R3: A rising edge of the load strobe writes the data byte into the addressed register; addresses 1 to 8 select digit registers 0 to 7, and no register changes without a load edge.
- R4: Address 9 stores all 8 decode bits, address 10 stores data bits 3:0 as intensity, address 11 stores bits 2:0 as scan limit, address 12 bit 0 equal to 1 leaves shutdown and 0 enters it, address 15 bit 0 sets display test.
- R5: A load with address 0 or address 13 changes no register output.
- R6: On every falling shift-clock edge the serial output takes bit 15 of the shift register, so the first bit of a frame appears after the falling edge that follows the 16th rising edge; it changes at no other time and is never high-impedance.
- R7: Address 14 stores bit 1 as soft reset and bit 0 as external clock select; while soft reset is 1 every other register is held at its R1 value and writes to them are lost, and address 14 itself is not cleared by it.
- R8: All registers accept writes while shutdown is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_din_i | input | 1 | Serial data in |
| ser_load_i | input | 1 | Load strobe, rising edge commits the frame |
| ser_dout_o | output | 1 | Serial data out for chaining |
| digits_o | output | 64 | Digit registers, digit g at bits g*8+7:g*8 |
| decode_o | output | 8 | Per-digit decode enables |
| intensity_o | output | 4 | Brightness level |
| scan_limit_o | output | 3 | Highest scanned digit index |
| shutdown_o | output | 1 | 1 while shutdown is active |
| disp_test_o | output | 1 | Display test flag |
| soft_rst_o | output | 1 | Soft-reset bit of the configuration register |
| ext_clk_o | output | 1 | External clock select bit |

## Verification
The hardest state to reach is the soft-reset hold, where a write to an ordinary register must be lost while the configuration register keeps its value, and then a later write must take effect once the bit is cleared. The bench gets there by a configuration frame with both bits set, a brightness and digit frame under the hold, and configuration frames that release it step by step. The chaining output is exercised by back-to-back frames, including a no-op that pushes the previous frame out, with the reference model tracking the output after every falling shift-clock edge.

// File: rtl/segcmd_pkg.sv
package segcmd_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_LO = 8;

  localparam logic [ADDR_W-1:0] A_NOOP   = 4'h0;
  localparam logic [ADDR_W-1:0] A_DIG0   = 4'h1;
  localparam logic [ADDR_W-1:0] A_DECODE = 4'h9;
  localparam logic [ADDR_W-1:0] A_INTENS = 4'hA;
  localparam logic [ADDR_W-1:0] A_SCAN   = 4'hB;
  localparam logic [ADDR_W-1:0] A_SHDN   = 4'hC;
  localparam logic [ADDR_W-1:0] A_SPARE  = 4'hD;
  localparam logic [ADDR_W-1:0] A_CFG    = 4'hE;
  localparam logic [ADDR_W-1:0] A_TEST   = 4'hF;

  typedef struct packed {
    logic [7:0] decode;
    logic [3:0] intens;
    logic [2:0] scan;
    logic       run;
    logic       test;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{decode: 8'h00, intens: 4'h0, scan: 3'h0, run: 1'b0, test: 1'b0};
endpackage

// File: rtl/segcmd_sync.sv
module segcmd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign q_o    = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/segcmd_shifter.sv
module segcmd_shifter #(
  parameter int FRAME_W = segcmd_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               out_en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame_o,
  output logic               dout_o
);
  logic [FRAME_W-1:0] sr_q;
  logic               dout_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst)         dout_q <= 1'b0;
    else if (out_en) dout_q <= sr_q[FRAME_W-1];
  end

  assign frame_o = sr_q;
  assign dout_o  = dout_q;
endmodule

// File: rtl/segcmd_regs.sv
module segcmd_regs
  import segcmd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int DW         = DATA_W,
  parameter int AW         = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NUM_DIGITS*DW-1:0] digits_o,
  output ctrl_t                    ctrl_o,
  output logic [1:0]               cfg_o
);
  logic [DW-1:0] dig_q [NUM_DIGITS];
  ctrl_t         ctrl_q;
  logic [1:0]    cfg_q;
  logic          hold_dflt;

  assign hold_dflt = cfg_q[1];

  always_ff @(posedge clk) begin
    if (rst)                                   cfg_q <= 2'b00;
    else if (wr_en && wr_addr == A_CFG)        cfg_q <= wr_data[1:0];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_dig
      localparam logic [AW-1:0] MY_ADDR = AW'(int'(A_DIG0) + g);
      always_ff @(posedge clk) begin
        if (rst || hold_dflt)                  dig_q[g] <= '0;
        else if (wr_en && wr_addr == MY_ADDR)  dig_q[g] <= wr_data;
      end
      assign digits_o[g*DW +: DW] = dig_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || hold_dflt) begin
      ctrl_q <= CTRL_DEFAULT;
    end else if (wr_en) begin
      case (wr_addr)
        A_DECODE: ctrl_q.decode <= wr_data[7:0];
        A_INTENS: ctrl_q.intens <= wr_data[3:0];
        A_SCAN:   ctrl_q.scan   <= wr_data[2:0];
        A_SHDN:   ctrl_q.run    <= wr_data[0];
        A_TEST:   ctrl_q.test   <= wr_data[0];
        default:  ctrl_q        <= ctrl_q;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/seg_cmd_port.sv
module seg_cmd_port
  import segcmd_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ser_clk_i,
  input  logic                         ser_din_i,
  input  logic                         ser_load_i,
  output logic                         ser_dout_o,
  output logic [NUM_DIGITS*DATA_W-1:0] digits_o,
  output logic [7:0]                   decode_o,
  output logic [3:0]                   intensity_o,
  output logic [2:0]                   scan_limit_o,
  output logic                         shutdown_o,
  output logic                         disp_test_o,
  output logic                         soft_rst_o,
  output logic                         ext_clk_o
);
  localparam int PIN_W = 3;
  localparam int P_CLK = 0;
  localparam int P_DIN = 1;
  localparam int P_LD  = 2;

  logic [PIN_W-1:0]   pins_s, pins_rise, pins_fall;
  logic               bit_rise, bit_fall, load_rise;
  logic [FRAME_W-1:0] frame;
  ctrl_t              ctrl;
  logic [1:0]         cfg;

  segcmd_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    ({ser_load_i, ser_din_i, ser_clk_i}),
    .q_o    (pins_s),
    .rise_o (pins_rise),
    .fall_o (pins_fall)
  );

  assign bit_rise  = pins_rise[P_CLK];
  assign bit_fall  = pins_fall[P_CLK];
  assign load_rise = pins_rise[P_LD];

  segcmd_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bit_rise),
    .out_en   (bit_fall),
    .din      (pins_s[P_DIN]),
    .frame_o  (frame),
    .dout_o   (ser_dout_o)
  );

  segcmd_regs #(.NUM_DIGITS(NUM_DIGITS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (load_rise),
    .wr_addr  (frame[ADDR_LO +: ADDR_W]),
    .wr_data  (frame[DATA_W-1:0]),
    .digits_o (digits_o),
    .ctrl_o   (ctrl),
    .cfg_o    (cfg)
  );

  assign decode_o     = ctrl.decode;
  assign intensity_o  = ctrl.intens;
  assign scan_limit_o = ctrl.scan;
  assign shutdown_o   = ~ctrl.run;
  assign disp_test_o  = ctrl.test;
  assign soft_rst_o   = cfg[1];
  assign ext_clk_o    = cfg[0];
endmodule

// File: rtl/seg_cmd_port_chk.sv
module seg_cmd_port_chk #(
  parameter int FRAME_W = 16,
  parameter int DIG_W   = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               bit_rise,
  input logic               bit_fall,
  input logic               load_rise,
  input logic [FRAME_W-1:0] frame,
  input logic               dout,
  input logic [DIG_W-1:0]   digits,
  input logic [7:0]         decode,
  input logic [3:0]         intensity,
  input logic [2:0]         scan,
  input logic               shutdown,
  input logic               test,
  input logic               srst,
  input logic               ext
);
  logic [DIG_W+17:0] all_regs;
  assign all_regs = {digits, decode, intensity, scan, shutdown, test, srst, ext};

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (digits == '0 && decode == 8'h00 && intensity == 4'h0 && scan == 3'h0 && shutdown && !test && !srst && !ext && !dout)); // R1

  AST_SHIFT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !bit_rise |=> $stable(frame)); // R2

  AST_NO_WRITE_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!load_rise && !srst) |=> $stable(all_regs)); // R3

  AST_INTENSITY_TAKES_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (load_rise && frame[11:8] == 4'hA && !srst) |=> intensity == $past(frame[3:0])); // R4

  AST_NOOP_AND_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (load_rise && (frame[11:8] == 4'h0 || frame[11:8] == 4'hD)) |=> $stable(all_regs)); // R5

  AST_DOUT_MOVES_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    !bit_fall |=> $stable(dout)); // R6

  AST_DOUT_TAKES_MSB: assert property (@(posedge clk) disable iff (rst)
    bit_fall |=> dout == $past(frame[FRAME_W-1])); // R6

  AST_SOFT_RESET_HOLDS_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    srst |=> (digits == '0 && decode == 8'h00 && intensity == 4'h0 && scan == 3'h0 && shutdown && !test)); // R7
endmodule

bind seg_cmd_port seg_cmd_port_chk #(.FRAME_W(segcmd_pkg::FRAME_W), .DIG_W(NUM_DIGITS*segcmd_pkg::DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_rise  (bit_rise),
  .bit_fall  (bit_fall),
  .load_rise (load_rise),
  .frame     (frame),
  .dout      (ser_dout_o),
  .digits    (digits_o),
  .decode    (decode_o),
  .intensity (intensity_o),
  .scan      (scan_limit_o),
  .shutdown  (shutdown_o),
  .test      (disp_test_o),
  .srst      (soft_rst_o),
  .ext       (ext_clk_o)
);

// File: tb/seg_cmd_port_tb_top.sv
module seg_cmd_port_tb_top;
  localparam int HOLD  = 8;
  localparam int QUIET = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdin = 1'b0, sload = 1'b0;
  logic        dout;
  logic [63:0] digits;
  logic [7:0]  decode;
  logic [3:0]  intensity;
  logic [2:0]  scan;
  logic        shutdown, dtest, srst, ext;

  always #10 clk = ~clk;

  seg_cmd_port dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_din_i(sdin), .ser_load_i(sload),
    .ser_dout_o(dout), .digits_o(digits), .decode_o(decode), .intensity_o(intensity),
    .scan_limit_o(scan), .shutdown_o(shutdown), .disp_test_o(dtest),
    .soft_rst_o(srst), .ext_clk_o(ext)
  );

  // behavioural reference model
  logic [7:0]  m_dig [8];
  logic [7:0]  m_dec;
  logic [3:0]  m_int;
  logic [2:0]  m_scan;
  logic        m_run, m_test;
  logic [1:0]  m_cfg;
  bit          m_sr [$];
  logic        m_dout;

  int    n_checks = 0;
  int    n_fails  = 0;
  string phase_req = "R1";
  bit    in_reset = 1'b1;
  int    quiet = 0;
  logic [2:0] last_pins = 3'b000;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_defaults_except_cfg();
    for (int i = 0; i < 8; i++) m_dig[i] = 8'h00;
    m_dec = 8'h00; m_int = 4'h0; m_scan = 3'h0; m_run = 1'b0; m_test = 1'b0;
  endtask

  task automatic model_load();
    logic [15:0] f;
    int a;
    f = '0;
    for (int i = 0; i < 16; i++) f[i] = m_sr[m_sr.size()-1-i];
    a = int'(f[11:8]);
    if (a == 14) begin
      m_cfg = f[1:0];
      if (m_cfg[1]) model_defaults_except_cfg();
    end else if (!m_cfg[1]) begin
      if (a >= 1 && a <= 8) m_dig[a-1] = f[7:0];
      else if (a == 9)  m_dec  = f[7:0];
      else if (a == 10) m_int  = f[3:0];
      else if (a == 11) m_scan = f[2:0];
      else if (a == 12) m_run  = f[0];
      else if (a == 15) m_test = f[0];
    end
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [15:0] f);
    for (int i = 15; i >= 0; i--) begin
      sdin = f[i];
      hold();
      sclk = 1'b1;
      m_sr.push_back(f[i]);
      if (m_sr.size() > 16) void'(m_sr.pop_front());
      hold();
      sclk = 1'b0;
      m_dout = (m_sr.size() == 16) ? m_sr[0] : 1'b0;
      hold();
    end
    sload = 1'b1;
    model_load();
    hold();
    sload = 1'b0;
    hold();
  endtask

  // per-clock comparison once the pins have been still long enough
  always @(negedge clk) begin
    if ({sclk, sdin, sload} != last_pins) quiet = 0;
    else if (quiet < 1000) quiet++;
    last_pins = {sclk, sdin, sload};
    if (!in_reset && quiet >= QUIET) begin
      for (int i = 0; i < 8; i++) check("R3", $sformatf("digit%0d", i), 64'(digits[i*8 +: 8]), 64'(m_dig[i]));
      check(phase_req, "decode", 64'(decode), 64'(m_dec));
      check(phase_req, "intensity", 64'(intensity), 64'(m_int));
      check(phase_req, "scan", 64'(scan), 64'(m_scan));
      check(phase_req, "shutdown", 64'(shutdown), 64'(!m_run));
      check(phase_req, "test", 64'(dtest), 64'(m_test));
      check("R7", "soft_rst", 64'(srst), 64'(m_cfg[1]));
      check("R7", "ext_clk", 64'(ext), 64'(m_cfg[0]));
      check("R6", "dout", 64'(dout), 64'(m_dout));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired in phase %s", phase_req);
    finish_run();
  end

  initial begin
    model_defaults_except_cfg();
    m_cfg = 2'b00;
    m_dout = 1'b0;
    repeat (5) @(negedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: explicit reset-state check
    check("R1", "digits", digits, 64'h0);
    check("R1", "shutdown", 64'(shutdown), 64'h1);
    check("R1", "scan", 64'(scan), 64'h0);
    check("R1", "dout", 64'(dout), 64'h0);
    in_reset = 1'b0;
    #1;

    // R2/R3: digit writes with junk in bits 15:12
    phase_req = "R2";
    for (int d = 0; d < 8; d++) send_frame({4'(d * 3 + 5), 4'(d + 1), 8'(8'hA5 ^ (d * 8'h11))});

    // R4: control registers, extra high data bits dropped
    phase_req = "R4";
    send_frame(16'hF9_3C);
    send_frame(16'h0A_FC);
    send_frame(16'h0B_FD);
    send_frame(16'h0C_01);
    send_frame(16'h0F_FF);
    send_frame(16'h0F_00);
    check("R4", "intensity", 64'(intensity), 64'hC);
    check("R4", "scan", 64'(scan), 64'h5);

    // R5: no-op and spare address leave everything
    phase_req = "R5";
    send_frame(16'h00_77);
    send_frame(16'h0D_FF);
    check("R5", "decode", 64'(decode), 64'h3C);
    check("R5", "digit0", 64'(digits[7:0]), 64'hA5);

    // R8: enter shutdown, keep writing
    phase_req = "R8";
    send_frame(16'h0C_00);
    send_frame(16'h03_5A);
    send_frame(16'h0A_07);
    check("R8", "digit2", 64'(digits[23:16]), 64'h5A);
    check("R8", "intensity", 64'(intensity), 64'h7);

    // R7: soft reset hold, writes lost, then release
    phase_req = "R7";
    send_frame(16'h0E_03);
    send_frame(16'h0A_09);
    send_frame(16'h01_EE);
    check("R7", "intensity held", 64'(intensity), 64'h0);
    check("R7", "digit0 held", 64'(digits[7:0]), 64'h00);
    check("R7", "ext_clk kept", 64'(ext), 64'h1);
    send_frame(16'h0E_01);
    send_frame(16'h0A_09);
    check("R7", "intensity after release", 64'(intensity), 64'h9);
    send_frame(16'h0E_00);

    // R6: chaining, a frame pushed out by a no-op
    phase_req = "R6";
    send_frame(16'hB2_C4);
    send_frame(16'h00_00);
    send_frame(16'hFF_FF);
    check("R6", "test after all-ones frame", 64'(dtest), 64'h1);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule